// File: doc/BRIEF.md
# Flash Status Register and Read-Source Controller

This block holds the status byte of a parallel NOR flash command interface and decides where read data comes from. It receives command strobes that an upstream decoder has already recognised, together with event and level signals from the internal write state machine, and it produces three things. The first is the formatted status value for the data bus. The second is a read-source code for the read multiplexer. The third is a start pulse for program or erase operations that are allowed to run.

Failure flags for program and erase are sticky. Once set, they block every further program or erase command until software issues Clear Status. The status byte is frozen when the combined enable-low condition begins, so one read cycle always returns one consistent value. Program and erase commands switch reads to the status register by themselves, so software can poll completion without a separate Read Status command.

All inputs are synchronous to `clk`. A synchronous active-high `rst` covers both power-up and exit from deep power-down.

Top module: `flash_status_ctl`

## Requirements
- R1: After reset, `read_src` is 0 (array) and `op_start` is 0. A status read then returns bits 7..4 = 1000b and bit 2 = 0.
- R2: A `wsm_prog_fail` pulse sets status bit 4 and a `wsm_erase_fail` pulse sets bit 5. Each bit stays set through any write-state-machine activity and is cleared only by `cmd_clear_status`. When a set and a clear arrive in the same cycle, the set wins.
- R3: A program, sector-erase or chip-erase strobe makes `op_start` high for exactly the following cycle, but only when bits 4 and 5 are both clear at the time of the strobe. Otherwise `op_start` stays low.
- R4: Each command selects a read source, encoded as 0 = array, 1 = status, 2 = ID:
  - Read Status, Program, Sector Erase and Chip Erase select status (`read_src` = 1), whether or not the operation is accepted.
  - Read Array selects 0.
  - Read ID selects 2.
  - Clear Status leaves `read_src` unchanged.
- R5: When status is driven, bits 7..2 carry the status and bits 1..0 read 0.
  - In word mode (`byte_mode` = 0), all 16 lanes are enabled and bits 15..8 read 00h.
  - In byte mode, `dq_oe[15:8]` is 0.
- R6: `dq_oe` is nonzero only when `read_src` = 1 and both `ce_n` and `oe_n` are low, starting from the second cycle of that condition. Whenever `dq_oe` is 0, `dq_out` is 0.
- R7: The driven value is the status sampled at the clock edge where the combined enable-low condition first becomes true, whichever enable fell last. It is held until either enable rises, so a change becomes visible only in the next read cycle.
- R8: Bit 3 equals `sect_protect` at capture time. Clear Status does not affect it.
- R9: `sleep_flag` or `abort_flag` sets bit 2. Clear Status does not clear it; only `cmd_read_array` does.
- R10: Bit 7 equals the inverse of `wsm_busy` and bit 6 equals `wsm_suspend`, each with one register of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up or deep power-down exit) |
| cmd_read_array | input | 1 | Read Array command strobe |
| cmd_read_status | input | 1 | Read Status command strobe |
| cmd_clear_status | input | 1 | Clear Status command strobe |
| cmd_program | input | 1 | Page Program command strobe |
| cmd_sector_erase | input | 1 | Sector Erase command strobe |
| cmd_chip_erase | input | 1 | Chip Erase command strobe |
| cmd_read_id | input | 1 | Read ID command strobe |
| wsm_busy | input | 1 | Write state machine busy level |
| wsm_suspend | input | 1 | Write state machine suspended level |
| wsm_prog_fail | input | 1 | Program failure event |
| wsm_erase_fail | input | 1 | Erase failure event |
| sect_protect | input | 1 | Sector-protect status level |
| sleep_flag | input | 1 | Sleep mode active |
| abort_flag | input | 1 | Abort mode active |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| dq_out | output | 16 | Data bus value for status reads |
| dq_oe | output | 16 | Per-bit output drive enables |
| read_src | output | 2 | Read source: 0 array, 1 status, 2 ID |
| op_start | output | 1 | Accepted program/erase start pulse |

## Verification
The bench checks that fail bits survive the write state machine going idle and busy again. A design that let the machine clear them would report success after a failure. It issues program and erase commands while a fail bit is set and expects no start pulse; a design that ignored the block would restart an operation on a failed part. It moves `wsm_busy` during an open read cycle, and opens read cycles with the two enables falling in either order. A design that sampled on the wrong edge or did not hold the value would show a changing byte mid-cycle or a stale byte. Sleep and abort are cleared only by Read Array, and Clear Status must neither alter the read source nor the protect bit.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int DQ_W   = 16;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_ID     = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic       ready;
        logic       suspend;
        logic       erase_fail;
        logic       prog_fail;
        logic       protect;
        logic       sleep;
        logic [1:0] rsvd;
    } stat_t;

    localparam stat_t STAT_RESET = '{ready: 1'b1, suspend: 1'b0, erase_fail: 1'b0,
                                     prog_fail: 1'b0, protect: 1'b0, sleep: 1'b0,
                                     rsvd: 2'b00};

    // Status byte as it appears on the lowest lane; reserved bits forced low.
    function automatic logic [LANE_W-1:0] stat_lane(input stat_t s);
        stat_t t;
        t      = s;
        t.rsvd = 2'b00;
        return LANE_W'(t);
    endfunction

endpackage

// File: rtl/fsc_status_reg.sv
module fsc_status_reg
    import fsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wsm_busy,
    input  logic  wsm_suspend,
    input  logic  wsm_prog_fail,
    input  logic  wsm_erase_fail,
    input  logic  clr_cmd,
    input  logic  rd_array_cmd,
    input  logic  sleep_flag,
    input  logic  abort_flag,
    input  logic  sect_protect,
    output stat_t stat
);

    logic ready_q, susp_q, pf_q, ef_q, sleep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= STAT_RESET.ready;
            susp_q  <= STAT_RESET.suspend;
            pf_q    <= STAT_RESET.prog_fail;
            ef_q    <= STAT_RESET.erase_fail;
            sleep_q <= STAT_RESET.sleep;
        end else begin
            ready_q <= ~wsm_busy;
            susp_q  <= wsm_suspend;
            // Sticky: only software clear removes them, a new event wins.
            pf_q    <= wsm_prog_fail  | (pf_q & ~clr_cmd);
            ef_q    <= wsm_erase_fail | (ef_q & ~clr_cmd);
            sleep_q <= sleep_flag | abort_flag | (sleep_q & ~rd_array_cmd);
        end
    end

    always_comb begin
        stat            = STAT_RESET;
        stat.ready      = ready_q;
        stat.suspend    = susp_q;
        stat.erase_fail = ef_q;
        stat.prog_fail  = pf_q;
        stat.protect    = sect_protect;
        stat.sleep      = sleep_q;
        stat.rsvd       = 2'b00;
    end

endmodule

// File: rtl/fsc_src_sel.sv
module fsc_src_sel
    import fsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_read_array,
    input  logic    cmd_read_status,
    input  logic    cmd_read_id,
    input  logic    cmd_program,
    input  logic    cmd_sector_erase,
    input  logic    cmd_chip_erase,
    input  logic    fail_block,
    output rd_src_e src,
    output logic    op_start
);

    logic pe_cmd;
    assign pe_cmd = cmd_program | cmd_sector_erase | cmd_chip_erase;

    always_ff @(posedge clk) begin
        if (rst) begin
            src      <= SRC_ARRAY;
            op_start <= 1'b0;
        end else begin
            op_start <= pe_cmd & ~fail_block;
            if (cmd_read_array)
                src <= SRC_ARRAY;
            else if (cmd_read_id)
                src <= SRC_ID;
            else if (cmd_read_status | pe_cmd)
                src <= SRC_STATUS;
        end
    end

endmodule

// File: rtl/fsc_bus_out.sv
module fsc_bus_out
    import fsc_pkg::*;
#(
    parameter int DQ_W   = fsc_pkg::DQ_W,
    parameter int LANE_W = fsc_pkg::LANE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  stat_t           stat,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            byte_mode,
    input  logic            show_status,
    output logic [DQ_W-1:0] dq_out,
    output logic [DQ_W-1:0] dq_oe
);

    localparam int NLANES = DQ_W / LANE_W;

    logic  en_low, en_q, drive;
    stat_t snap_q;

    assign en_low = ~ce_n & ~oe_n;
    assign drive  = en_low & en_q & show_status;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            snap_q <= STAT_RESET;
        end else begin
            en_q <= en_low;
            if (en_low & ~en_q)
                snap_q <= stat;
        end
    end

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign dq_out[LANE_W-1:0] = drive ? stat_lane(snap_q) : '0;
            assign dq_oe[LANE_W-1:0]  = {LANE_W{drive}};
        end else begin : g_high
            assign dq_out[g*LANE_W +: LANE_W] = '0;
            assign dq_oe[g*LANE_W +: LANE_W]  = {LANE_W{drive & ~byte_mode}};
        end
    end

endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
    import fsc_pkg::*;
#(
    parameter int DQ_W = fsc_pkg::DQ_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_read_array,
    input  logic            cmd_read_status,
    input  logic            cmd_clear_status,
    input  logic            cmd_program,
    input  logic            cmd_sector_erase,
    input  logic            cmd_chip_erase,
    input  logic            cmd_read_id,
    input  logic            wsm_busy,
    input  logic            wsm_suspend,
    input  logic            wsm_prog_fail,
    input  logic            wsm_erase_fail,
    input  logic            sect_protect,
    input  logic            sleep_flag,
    input  logic            abort_flag,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            byte_mode,
    output logic [DQ_W-1:0] dq_out,
    output logic [DQ_W-1:0] dq_oe,
    output logic [1:0]      read_src,
    output logic            op_start
);

    stat_t   stat;
    rd_src_e src;
    logic    pf_w, ef_w;

    assign pf_w     = stat.prog_fail;
    assign ef_w     = stat.erase_fail;
    assign read_src = src;

    fsc_status_reg u_stat (
        .clk            (clk),
        .rst            (rst),
        .wsm_busy       (wsm_busy),
        .wsm_suspend    (wsm_suspend),
        .wsm_prog_fail  (wsm_prog_fail),
        .wsm_erase_fail (wsm_erase_fail),
        .clr_cmd        (cmd_clear_status),
        .rd_array_cmd   (cmd_read_array),
        .sleep_flag     (sleep_flag),
        .abort_flag     (abort_flag),
        .sect_protect   (sect_protect),
        .stat           (stat)
    );

    fsc_src_sel u_src (
        .clk              (clk),
        .rst              (rst),
        .cmd_read_array   (cmd_read_array),
        .cmd_read_status  (cmd_read_status),
        .cmd_read_id      (cmd_read_id),
        .cmd_program      (cmd_program),
        .cmd_sector_erase (cmd_sector_erase),
        .cmd_chip_erase   (cmd_chip_erase),
        .fail_block       (pf_w | ef_w),
        .src              (src),
        .op_start         (op_start)
    );

    fsc_bus_out #(.DQ_W(DQ_W), .LANE_W(LANE_W)) u_bus (
        .clk         (clk),
        .rst         (rst),
        .stat        (stat),
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .byte_mode   (byte_mode),
        .show_status (src == SRC_STATUS),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe)
    );

endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk #(
    parameter int DQ_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_read_array,
    input logic            cmd_read_status,
    input logic            cmd_clear_status,
    input logic            cmd_program,
    input logic            cmd_sector_erase,
    input logic            cmd_chip_erase,
    input logic            cmd_read_id,
    input logic            ce_n,
    input logic            oe_n,
    input logic            byte_mode,
    input logic            pf,
    input logic            ef,
    input logic [DQ_W-1:0] dq_out,
    input logic [DQ_W-1:0] dq_oe,
    input logic [1:0]      read_src,
    input logic            op_start
);

    logic pe_cmd;
    assign pe_cmd = cmd_program | cmd_sector_erase | cmd_chip_erase;

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((pf || ef) && !cmd_clear_status) |=> (pf || ef)) else $error("sticky fail lost"); // R2

    AST_OP_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (pe_cmd && (pf || ef)) |=> !op_start) else $error("blocked op started"); // R3

    AST_SRC_STATUS: assert property (@(posedge clk) disable iff (rst)
        ((cmd_read_status || pe_cmd) && !cmd_read_array && !cmd_read_id) |=> (read_src == 2'd1))
        else $error("status source not selected"); // R4

    AST_CLR_KEEPS_SRC: assert property (@(posedge clk) disable iff (rst)
        (cmd_clear_status && !cmd_read_status && !cmd_read_array && !cmd_read_id && !pe_cmd)
        |=> $stable(read_src)) else $error("clear changed source"); // R4

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        dq_oe[0] |-> (dq_out[1:0] == 2'b00 && dq_out[DQ_W-1:8] == '0))
        else $error("reserved bits driven"); // R5

    AST_BYTE_LANES: assert property (@(posedge clk) disable iff (rst)
        byte_mode |-> (dq_oe[DQ_W-1:8] == '0)) else $error("upper lanes driven in byte mode"); // R5

    AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> (dq_oe == '0 && dq_out == '0)) else $error("driven while disabled"); // R6

    AST_HOLD_READ: assert property (@(posedge clk) disable iff (rst)
        (dq_oe[0] && $past(dq_oe[0])) |-> $stable(dq_out)) else $error("value moved in read"); // R7

endmodule

bind flash_status_ctl flash_status_chk #(.DQ_W(DQ_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .cmd_read_array   (cmd_read_array),
    .cmd_read_status  (cmd_read_status),
    .cmd_clear_status (cmd_clear_status),
    .cmd_program      (cmd_program),
    .cmd_sector_erase (cmd_sector_erase),
    .cmd_chip_erase   (cmd_chip_erase),
    .cmd_read_id      (cmd_read_id),
    .ce_n             (ce_n),
    .oe_n             (oe_n),
    .byte_mode        (byte_mode),
    .pf               (pf_w),
    .ef               (ef_w),
    .dq_out           (dq_out),
    .dq_oe            (dq_oe),
    .read_src         (read_src),
    .op_start         (op_start)
);

// File: tb/flash_status_ctl_test.sv
module flash_status_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic c_ra = 0, c_rs = 0, c_clr = 0, c_pg = 0, c_se = 0, c_ce = 0, c_id = 0;
    logic busy = 0, susp = 0, pfail = 0, efail = 0, prot = 0, slp = 0, abrt = 0;
    logic ce_n = 1, oe_n = 1, byte_mode = 0;
    logic [15:0] dq_out, dq_oe;
    logic [1:0]  read_src;
    logic        op_start;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit started = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_ctl uut (
        .clk(clk), .rst(rst),
        .cmd_read_array(c_ra), .cmd_read_status(c_rs), .cmd_clear_status(c_clr),
        .cmd_program(c_pg), .cmd_sector_erase(c_se), .cmd_chip_erase(c_ce),
        .cmd_read_id(c_id), .wsm_busy(busy), .wsm_suspend(susp),
        .wsm_prog_fail(pfail), .wsm_erase_fail(efail), .sect_protect(prot),
        .sleep_flag(slp), .abort_flag(abrt), .ce_n(ce_n), .oe_n(oe_n),
        .byte_mode(byte_mode), .dq_out(dq_out), .dq_oe(dq_oe),
        .read_src(read_src), .op_start(op_start)
    );

    // Behavioural reference model
    bit       m_ready, m_susp, m_pf, m_ef, m_sleep, m_op, m_enq;
    int       m_src;
    bit [7:0] m_snap;

    always @(posedge clk) begin
        bit [7:0] cur;
        bit enl, pe;
        started <= 1;
        if (rst) begin
            m_ready = 1; m_susp = 0; m_pf = 0; m_ef = 0; m_sleep = 0;
            m_op = 0; m_enq = 0; m_src = 0; m_snap = 8'h80;
        end else begin
            cur = {m_ready, m_susp, m_ef, m_pf, prot, m_sleep, 2'b00};
            enl = !ce_n && !oe_n;
            if (enl && !m_enq) m_snap = cur;
            m_enq = enl;
            pe = c_pg || c_se || c_ce;
            m_op = pe && !m_pf && !m_ef;
            m_pf = (m_pf && !c_clr) || pfail;
            m_ef = (m_ef && !c_clr) || efail;
            m_sleep = (m_sleep && !c_ra) || slp || abrt;
            m_ready = !busy;
            m_susp = susp;
            if (c_ra) m_src = 0;
            else if (c_id) m_src = 2;
            else if (c_rs || pe) m_src = 1;
        end
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit on;
        logic [15:0] e_oe, e_dq;
        if (started && !rst) begin
            on   = m_enq && !ce_n && !oe_n && (m_src == 1);
            e_oe = on ? (byte_mode ? 16'h00FF : 16'hFFFF) : 16'h0000;
            e_dq = on ? {8'h00, m_snap} : 16'h0000;
            check({14'd0, read_src}, m_src[15:0], "R4 model read_src");
            check({15'd0, op_start}, {15'd0, m_op}, "R3 model op_start");
            check(dq_oe, e_oe, "R6 model dq_oe");
            check(dq_out, e_dq, "R7 model dq_out");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1;
        @(negedge clk); s = 0;
    endtask

    task automatic read_expect(input logic [15:0] exp_dq, input logic [15:0] exp_oe, input string tag);
        @(negedge clk); ce_n = 0; oe_n = 0;
        @(negedge clk);
        check(dq_out, exp_dq, tag);
        check(dq_oe, exp_oe, tag);
        @(negedge clk); ce_n = 1; oe_n = 1;
    endtask

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        check({14'd0, read_src}, 16'd0, "R1 reset source");
        check({15'd0, op_start}, 16'd0, "R1 reset op_start");
        read_expect(16'h0000, 16'h0000, "R6 array read not driven");

        pulse(c_rs);
        check({14'd0, read_src}, 16'd1, "R4 read status select");
        read_expect(16'h0080, 16'hFFFF, "R1 R5 reset status word mode");
        byte_mode = 1;
        read_expect(16'h0080, 16'h00FF, "R5 byte mode lanes");
        byte_mode = 0;

        prot = 1;
        read_expect(16'h0088, 16'hFFFF, "R8 protect bit");
        pulse(c_clr);
        read_expect(16'h0088, 16'hFFFF, "R8 protect survives clear");
        prot = 0;

        pulse(c_ra);
        pulse(c_pg);
        check({15'd0, op_start}, 16'd1, "R3 program accepted");
        check({14'd0, read_src}, 16'd1, "R4 program selects status");
        busy = 1; idle(2);
        read_expect(16'h0000, 16'hFFFF, "R10 busy clears ready");
        pulse(pfail);
        busy = 0; idle(2);
        read_expect(16'h0090, 16'hFFFF, "R2 program fail set");
        pulse(c_se);
        check({15'd0, op_start}, 16'd0, "R3 sector erase blocked");
        pulse(c_ce);
        check({15'd0, op_start}, 16'd0, "R3 chip erase blocked");
        pulse(c_pg);
        check({15'd0, op_start}, 16'd0, "R3 program blocked");
        busy = 1; idle(2); busy = 0; idle(2);
        read_expect(16'h0090, 16'hFFFF, "R2 fail survives busy cycle");
        pulse(efail);
        read_expect(16'h00B0, 16'hFFFF, "R2 erase fail set");
        pulse(c_clr);
        check({14'd0, read_src}, 16'd1, "R4 clear keeps source");
        read_expect(16'h0080, 16'hFFFF, "R2 clear removes fails");
        pulse(c_pg);
        check({15'd0, op_start}, 16'd1, "R3 program accepted after clear");

        susp = 1; idle(2);
        read_expect(16'h00C0, 16'hFFFF, "R10 suspend bit");
        susp = 0; idle(2);

        // Hold during an open read cycle
        @(negedge clk); ce_n = 0; oe_n = 0;
        @(negedge clk); busy = 1;
        idle(3);
        check(dq_out, 16'h0080, "R7 value held during read");
        ce_n = 1; oe_n = 1;
        read_expect(16'h0000, 16'hFFFF, "R7 next read shows change");
        busy = 0; idle(2);

        // Output enable first, chip enable falls last
        @(negedge clk); oe_n = 0; busy = 1;
        idle(3);
        ce_n = 0;
        @(negedge clk);
        check(dq_out, 16'h0000, "R7 capture on last falling enable");
        busy = 0; idle(3);
        check(dq_out, 16'h0000, "R7 held after busy drops");
        ce_n = 1; oe_n = 1;
        idle(2);

        pulse(slp);
        read_expect(16'h0084, 16'hFFFF, "R9 sleep sets bit 2");
        pulse(c_clr);
        read_expect(16'h0084, 16'hFFFF, "R9 clear keeps bit 2");
        pulse(c_ra);
        check({14'd0, read_src}, 16'd0, "R4 read array select");
        read_expect(16'h0000, 16'h0000, "R6 array not driven");
        pulse(c_rs);
        read_expect(16'h0080, 16'hFFFF, "R9 read array cleared bit 2");

        pulse(abrt);
        read_expect(16'h0084, 16'hFFFF, "R9 abort sets bit 2");
        pulse(c_ra);
        pulse(c_rs);
        read_expect(16'h0080, 16'hFFFF, "R9 abort bit cleared");

        pulse(c_id);
        check({14'd0, read_src}, 16'd2, "R4 read id select");
        read_expect(16'h0000, 16'h0000, "R6 id read not driven");
        pulse(c_clr);
        check({14'd0, read_src}, 16'd2, "R4 clear keeps id source");

        idle(3);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule